// File: doc/BRIEF.md
# 32-bit SEC-DED error correction unit

This block guards a 32-bit data word with 8 check bits. On the write side it produces the check bits for the word held in its input register. On the read side it compares freshly generated check bits against stored ones, forming an 8-bit syndrome. It then sorts the syndrome into one of four outcomes: clean, one bad bit (data or check), two bad bits, or three or more bad bits. When correction is on, it inverts a single failing data bit on the way to the output register.

A two-bit mode selects normal operation (generate, detect or correct, depending on the correct control), pass-through of the stored check bits, diagnostic operation against check bits held in a writable diagnostic register, or initialization to an all-zero word. The diagnostic register is loaded from the data input. When the internal select is high, its mode and correct fields take the place of the external controls.

Top module: `ecc_secded32`

## Requirements
- R1: In mode 00, chk_o is the XOR, over all set data bits i, of the column of bit i. The column of data bit i is the i-th (counting from 0) 8-bit value with exactly three ones, taken in ascending numeric order. The column of check bit j is 1<<j.
- R2: syn_o equals the generated check bits XOR the compare check bits. The compare bits are the registered chk_i in modes 00 and 01, and the diagnostic check field in mode 10.
- R3: class_o encodes 0 = no error, 1 = single, 2 = double, 3 = multiple. A zero syndrome gives class 0 with err_o=0 and mult_o=0.
- R4: A syndrome equal to the column of data bit i gives class 1 with bit_idx_o=i. A syndrome with only bit j set gives class 1 with bit_idx_o=32+j. In both cases err_o=1 and mult_o=0.
- R5: A non-zero even-weight syndrome gives class 2. An odd-weight syndrome that matches no column gives class 3. Both set err_o=1 and mult_o=1.
- R6: With correct active and a single data-bit class, data_o is the registered data with that bit inverted. With correct inactive, or with a check-bit single, data_o is the registered data unchanged.
- R7: In mode 01, chk_o equals the registered chk_i.
- R8: In mode 10, chk_o equals the diagnostic check field, and the syndrome is formed against that field.
- R9: In mode 11, data_o becomes 0, and chk_o and syn_o are 0 with class 0.
- R10: A rising edge with diag_le_ni low loads the diagnostic register from data_i: [7:0] check bits, [9:8] mode, [10] correct. While internal_i=1, the register's mode and correct fields replace mode_i and correct_i.
- R11: Data and check inputs are registered at a rising edge when din_le_ni is low. data_o loads at a rising edge when dout_le_ni is low and holds otherwise. rst_ni low clears all registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 32 | Data word, also diagnostic register source |
| chk_i | input | 8 | Stored check bits |
| din_le_ni | input | 1 | Input register load enable, active low |
| dout_le_ni | input | 1 | Output register load enable, active low |
| diag_le_ni | input | 1 | Diagnostic register load enable, active low |
| internal_i | input | 1 | Take mode and correct from the diagnostic register |
| mode_i | input | 2 | 00 normal, 01 pass-through, 10 diagnostic, 11 initialize |
| correct_i | input | 1 | Enable single-bit correction |
| data_o | output | 32 | Registered (corrected) data |
| chk_o | output | 8 | Check bit output |
| syn_o | output | 8 | Syndrome |
| class_o | output | 2 | Syndrome class |
| bit_idx_o | output | 6 | Index of the single failing bit (0-31 data, 32-39 check) |
| err_o | output | 1 | Any error detected |
| mult_o | output | 1 | Double or multiple error detected |

## Verification
Random words are stored with correct check bits, and then zero, one, two or three of the 40 code bits are inverted. Zero flips confirm a clean pass. One flip separates a data-bit fix from a check-bit report. Two flips must land in the double class. Three flips land in either the multiple class or an aliased single, and the expected syndrome is the XOR of the flipped columns. Directed cases cover the all-zero and all-one words, each mode, overriding the controls from the diagnostic register, and holding the input and output registers.

// File: rtl/ecc_secded_pkg.sv
package ecc_secded_pkg;
  localparam int DATA_W = 32;
  localparam int CHK_W  = 8;
  localparam int COL_WT = 3;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_PASS   = 2'b01,
    MODE_DIAG   = 2'b10,
    MODE_INIT   = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_SINGLE = 2'd1,
    CLS_DOUBLE = 2'd2,
    CLS_MULTI  = 2'd3
  } cls_e;

  typedef struct packed {
    logic              corr;
    mode_e             mode;
    logic [CHK_W-1:0]  chk;
  } diag_t;

  // idx-th CHK_W-bit value of weight COL_WT, ascending
  function automatic logic [CHK_W-1:0] data_col(int idx);
    int n;
    logic [CHK_W-1:0] cand;
    n = 0;
    for (int v = 0; v < (1 << CHK_W); v++) begin
      cand = v[CHK_W-1:0];
      if ($countones(cand) == COL_WT) begin
        if (n == idx) return cand;
        n++;
      end
    end
    return '0;
  endfunction
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_secded_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] chk_o
);
  logic [CW-1:0] term [DW];

  for (genvar i = 0; i < DW; i++) begin : g_col
    localparam logic [CW-1:0] COL = CW'(data_col(i));
    assign term[i] = data_i[i] ? COL : '0;
  end

  always_comb begin
    chk_o = '0;
    for (int i = 0; i < DW; i++) chk_o ^= term[i];
  end
endmodule

// File: rtl/ecc_chk_sel.sv
module ecc_chk_sel
  import ecc_secded_pkg::*;
#(
  parameter int CW = CHK_W
) (
  input  mode_e         mode_i,
  input  logic [CW-1:0] gen_i,
  input  logic [CW-1:0] stored_i,
  input  logic [CW-1:0] diag_i,
  output logic [CW-1:0] out_o,
  output logic [CW-1:0] cmp_o
);
  always_comb begin
    unique case (mode_i)
      MODE_NORMAL: begin out_o = gen_i;    cmp_o = stored_i; end
      MODE_PASS:   begin out_o = stored_i; cmp_o = stored_i; end
      MODE_DIAG:   begin out_o = diag_i;   cmp_o = diag_i;   end
      default:     begin out_o = gen_i;    cmp_o = gen_i;    end
    endcase
  end
endmodule

// File: rtl/ecc_syn_decode.sv
module ecc_syn_decode
  import ecc_secded_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W,
  parameter int IW = $clog2(DW + CW)
) (
  input  logic [CW-1:0] syn_i,
  output cls_e          cls_o,
  output logic [IW-1:0] idx_o,
  output logic [DW-1:0] flip_o
);
  logic [DW-1:0] hit;

  for (genvar i = 0; i < DW; i++) begin : g_hit
    localparam logic [CW-1:0] COL = CW'(data_col(i));
    assign hit[i] = (syn_i == COL);
  end

  always_comb begin
    cls_o  = CLS_NONE;
    idx_o  = '0;
    flip_o = '0;
    if (syn_i != '0) begin
      if (!(^syn_i)) begin
        cls_o = CLS_DOUBLE;
      end else if ($countones(syn_i) == 1) begin
        cls_o = CLS_SINGLE;
        for (int j = 0; j < CW; j++)
          if (syn_i[j]) idx_o = IW'(DW + j);
      end else if (|hit) begin
        cls_o  = CLS_SINGLE;
        flip_o = hit;
        for (int i = 0; i < DW; i++)
          if (hit[i]) idx_o = IW'(i);
      end else begin
        cls_o = CLS_MULTI;
      end
    end
  end
endmodule

// File: rtl/ecc_secded32.sv
module ecc_secded32
  import ecc_secded_pkg::*;
#(
  parameter  int DW = DATA_W,
  parameter  int CW = CHK_W,
  localparam int IW = $clog2(DW + CW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] chk_i,
  input  logic          din_le_ni,
  input  logic          dout_le_ni,
  input  logic          diag_le_ni,
  input  logic          internal_i,
  input  logic [1:0]    mode_i,
  input  logic          correct_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] chk_o,
  output logic [CW-1:0] syn_o,
  output logic [1:0]    class_o,
  output logic [IW-1:0] bit_idx_o,
  output logic          err_o,
  output logic          mult_o
);
  localparam int DG_W = $bits(diag_t);

  logic [DW-1:0] din_q, data_q, enc_in, data_c, flip;
  logic [CW-1:0] chk_q, gen, cmp;
  diag_t         diag_q;
  mode_e         mode_eff;
  logic          corr_eff;
  cls_e          cls;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      din_q  <= '0;
      chk_q  <= '0;
      data_q <= '0;
      diag_q <= '0;
    end else begin
      if (!din_le_ni) begin
        din_q <= data_i;
        chk_q <= chk_i;
      end
      if (!dout_le_ni) data_q <= data_c;
      if (!diag_le_ni) diag_q <= diag_t'(data_i[DG_W-1:0]);
    end
  end

  assign mode_eff = internal_i ? diag_q.mode : mode_e'(mode_i);
  assign corr_eff = internal_i ? diag_q.corr : correct_i;
  assign enc_in   = (mode_eff == MODE_INIT) ? '0 : din_q;

  ecc_encoder #(.DW(DW), .CW(CW)) i_enc (
    .data_i (enc_in),
    .chk_o  (gen)
  );

  ecc_chk_sel #(.CW(CW)) i_sel (
    .mode_i   (mode_eff),
    .gen_i    (gen),
    .stored_i (chk_q),
    .diag_i   (diag_q.chk),
    .out_o    (chk_o),
    .cmp_o    (cmp)
  );

  assign syn_o = gen ^ cmp;

  ecc_syn_decode #(.DW(DW), .CW(CW), .IW(IW)) i_dec (
    .syn_i  (syn_o),
    .cls_o  (cls),
    .idx_o  (bit_idx_o),
    .flip_o (flip)
  );

  always_comb begin
    if (mode_eff == MODE_INIT) data_c = '0;
    else if (corr_eff)         data_c = din_q ^ flip;
    else                       data_c = din_q;
  end

  assign data_o  = data_q;
  assign class_o = cls;
  assign err_o   = (cls != CLS_NONE);
  assign mult_o  = (cls == CLS_DOUBLE) || (cls == CLS_MULTI);

  // R11
  dout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_le_ni |=> $stable(data_o));
  // R10
  diag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diag_le_ni |=> $stable(diag_q));
  // R9
  init_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_eff == MODE_INIT) |-> (syn_o == '0 && chk_o == '0));
  // R5
  mult_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mult_o |-> err_o);
  // R6
  one_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dout_le_ni && mode_eff != MODE_INIT && corr_eff && cls == CLS_SINGLE
     && bit_idx_o < IW'(DW)) |=> ($countones(data_o ^ $past(din_q)) == 1));
endmodule

// File: tb/test_ecc_secded32.sv
`timescale 1ns/1ps
module test_ecc_secded32;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] data_i = '0;
  logic [7:0]  chk_i = '0;
  logic        din_le_n = 1'b0, dout_le_n = 1'b0, diag_le_n = 1'b1;
  logic        internal = 1'b0, correct = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [31:0] data_o;
  logic [7:0]  chk_o, syn_o;
  logic [1:0]  class_o;
  logic [5:0]  bit_idx_o;
  logic        err_o, mult_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ecc_secded32 i_ecc_secded32 (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data_i), .chk_i(chk_i),
    .din_le_ni(din_le_n), .dout_le_ni(dout_le_n), .diag_le_ni(diag_le_n),
    .internal_i(internal), .mode_i(mode), .correct_i(correct),
    .data_o(data_o), .chk_o(chk_o), .syn_o(syn_o), .class_o(class_o),
    .bit_idx_o(bit_idx_o), .err_o(err_o), .mult_o(mult_o));

  function automatic logic [7:0] col(int i);
    int n = 0;
    if (i >= 32) return 8'(1 << (i - 32));
    for (int v = 0; v < 256; v++)
      if ($countones(8'(v)) == 3) begin
        if (n == i) return 8'(v);
        n++;
      end
    return 8'h00;
  endfunction

  function automatic logic [7:0] enc(logic [31:0] w);
    logic [7:0] c = '0;
    for (int i = 0; i < 32; i++) if (w[i]) c ^= col(i);
    return c;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] d, logic [7:0] c);
    @(negedge clk);
    data_i = d; chk_i = c;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic trial(int nflip, bit corr);
    logic [31:0] w, din;
    logic [39:0] fl;
    logic [7:0]  s;
    int          pos, ecls, eidx;
    w  = $urandom();
    fl = '0;
    s  = '0;
    for (int k = 0; k < nflip; k++) begin
      do pos = $urandom_range(39); while (fl[pos]);
      fl[pos] = 1'b1;
      s ^= col(pos);
    end
    din = w ^ fl[31:0];
    mode = 2'b00; correct = corr; internal = 1'b0;
    apply(din, enc(w) ^ fl[39:32]);
    check("R2 syn", 64'(syn_o), 64'(s));
    ecls = 0; eidx = 0;
    if (s != 0) begin
      if (!(^s)) ecls = 2;
      else begin
        ecls = 3;
        for (int i = 0; i < 40; i++) if (s == col(i)) begin ecls = 1; eidx = i; end
      end
    end
    if (nflip == 1) check("R4 single class", 64'(class_o), 64'd1);
    if (nflip == 2) check("R5 double class", 64'(class_o), 64'd2);
    check("R3 class", 64'(class_o), 64'(ecls));
    check("R3 err", 64'(err_o), 64'(ecls != 0));
    check("R5 mult", 64'(mult_o), 64'(ecls >= 2));
    if (ecls == 1) check("R4 idx", 64'(bit_idx_o), 64'(eidx));
    if (ecls < 2) begin
      if (corr && ecls == 1 && eidx < 32) check("R6 corrected", 64'(data_o), 64'(din ^ (32'd1 << eidx)));
      else                                check("R6 data", 64'(data_o), 64'(din));
    end
  endtask

  initial begin
    void'($urandom(32'd7311));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check("R11 rst data", 64'(data_o), 64'd0);
    check("R11 rst syn", 64'(syn_o), 64'd0);
    check("R3 rst class", 64'(class_o), 64'd0);
    rst_n = 1'b1;

    // R1 generation
    apply(32'h0000_0001, 8'h00);
    check("R1 bit0", 64'(chk_o), 64'(8'h07));
    apply(32'hFFFF_FFFF, 8'h00);
    check("R1 ones", 64'(chk_o), 64'(enc(32'hFFFF_FFFF)));
    apply(32'h8000_0000, 8'h00);
    check("R1 bit31", 64'(chk_o), 64'(col(31)));

    // directed single on data bit 0 with and without correction
    correct = 1'b1;
    apply(32'h0000_0001, 8'h00);
    check("R4 idx0", 64'(bit_idx_o), 64'd0);
    check("R6 fix0", 64'(data_o), 64'd0);
    correct = 1'b0;
    apply(32'h0000_0001, 8'h00);
    check("R6 nocorr", 64'(data_o), 64'h1);
    // check-bit single leaves data
    correct = 1'b1;
    apply(32'h1234_5678, enc(32'h1234_5678) ^ 8'h80);
    check("R4 chk idx", 64'(bit_idx_o), 64'd39);
    check("R6 chk data", 64'(data_o), 64'h1234_5678);
    // odd weight-5 syndrome unmatched
    apply(32'h0, 8'h1F);
    check("R5 multi", 64'(class_o), 64'd3);
    check("R5 multi err", 64'(err_o), 64'd1);

    // R7 pass-through
    mode = 2'b01;
    apply(32'hCAFE_F00D, 8'h3C);
    check("R7 pass", 64'(chk_o), 64'(8'h3C));
    check("R7 syn", 64'(syn_o), 64'(enc(32'hCAFE_F00D) ^ 8'h3C));

    // R10 load diagnostic register: chk=A5, mode=00, corr=0
    mode = 2'b00;
    @(negedge clk);
    din_le_n = 1'b1; diag_le_n = 1'b0; data_i = 32'h0000_00A5;
    @(posedge clk); @(negedge clk);
    diag_le_n = 1'b1; din_le_n = 1'b0;
    // R8 diagnostic mode
    mode = 2'b10;
    apply(32'h0F0F_0F0F, 8'h00);
    check("R8 diag chk", 64'(chk_o), 64'(8'hA5));
    check("R8 diag syn", 64'(syn_o), 64'(enc(32'h0F0F_0F0F) ^ 8'hA5));
    // R10 internal overrides: latched corr=0 beats external correct=1
    mode = 2'b11; correct = 1'b1; internal = 1'b1;
    apply(32'h0000_0002, 8'h00);
    check("R10 ovr mode", 64'(chk_o), 64'(enc(32'h2)));
    check("R10 ovr corr", 64'(data_o), 64'h2);
    // latch mode=01 corr=1
    @(negedge clk);
    din_le_n = 1'b1; diag_le_n = 1'b0; data_i = 32'h0000_0500;
    @(posedge clk); @(negedge clk);
    diag_le_n = 1'b1; din_le_n = 1'b0;
    mode = 2'b00; correct = 1'b0;
    apply(32'h0000_0002, 8'h55);
    check("R10 latch pass", 64'(chk_o), 64'(8'h55));
    internal = 1'b0;

    // R9 init
    mode = 2'b11;
    apply(32'hDEAD_BEEF, 8'h77);
    check("R9 data", 64'(data_o), 64'd0);
    check("R9 chk", 64'(chk_o), 64'd0);
    check("R9 class", 64'(class_o), 64'd0);
    mode = 2'b00;

    // R11 hold: output then input registers
    correct = 1'b0;
    apply(32'h1111_1111, enc(32'h1111_1111));
    dout_le_n = 1'b1;
    apply(32'h2222_2222, enc(32'h2222_2222));
    check("R11 dout hold", 64'(data_o), 64'h1111_1111);
    dout_le_n = 1'b0; din_le_n = 1'b1;
    apply(32'h3333_3333, 8'hFF);
    check("R11 din hold", 64'(data_o), 64'h2222_2222);
    check("R11 din syn", 64'(syn_o), 64'd0);
    din_le_n = 1'b0;

    for (int n = 0; n < 400; n++) trial(n % 4, n[2]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R11 watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule